// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames in which every byte carries one extra marker bit. The marker bit tells an address frame, which names the node being spoken to, from a data frame. The receiver catches every address frame. It raises a receive-complete interrupt for it, so that software can compare the received ID with its own. When the IDs do not match, software clears a data-enable flag. From then on, data frames on the line are dropped in hardware. Dropped frames produce no interrupt, and their error state is discarded.

The line is oversampled by an external baud tick, sixteen ticks per bit. A frame is a start bit (low), eight data bits sent LSB first, the marker bit and a stop bit (high). Each bit is sampled at its mid-point. A power enable and a receive enable gate the receiver. A mode bit chooses whether a frame received with an error also raises the receive-complete interrupt, or raises only the error interrupt. The data-enable flag can only be cleared while the receiver is both powered and enabled.

Top module: `mpuart_rx`

## Requirements
- R1: A frame is a low start bit, 8 data bits LSB first, a marker bit and a stop bit, each lasting 16 baud ticks. On an accepted frame, `rx_data` takes the byte, `rx_addr` takes the marker bit, and `irq_rx` pulses for one clock when the frame has no error.
- R2: A start bit counts only if the line is still low at its mid-point sample, 8 ticks after the falling edge. A shorter low pulse returns the receiver to idle and produces no frame.
- R3: A frame whose marker bit is 1 is accepted whatever the state of `den_o`.
- R4: While `den_o` is 0, a frame whose marker bit is 0 is dropped. It gives no interrupt pulse and leaves `rx_data`, `rx_addr`, `err_frame` and `err_over` unchanged, even when its stop bit is low.
- R5: While `den_o` is 0, a marker-1 frame that has a low stop bit still has its error detected: `err_frame` is set to 1 and `irq_err` pulses.
- R6: When an accepted frame has an error, `irq_err` pulses. `irq_rx` also pulses only when `err_irq_only` is 0. When `err_irq_only` is 1, `irq_rx` stays low for that frame.
- R7: `den_o` is 1 after reset. A write of 1 always sets it. A write of 0 clears it only when `pwr_en` and `rx_en` are both 1. Whenever either of them is 0, the flag is held at 1.
- R8: On each accepted frame, `err_frame` is set to 1 when its stop bit was sampled low, and to 0 otherwise.
- R9: On each accepted frame, `err_over` is set to 1 when the previous accepted byte has not been read through `rd_byte`, and to 0 otherwise. The new byte replaces the old one.
- R10: After reset, `err_frame`, `err_over`, `irq_rx` and `irq_err` are 0, `rx_data` is 0 and the receiver is idle.
- R11: While `pwr_en` or `rx_en` is 0, the bit sampler is held idle and no start bit is recognised. A frame cut off by disabling produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power enable for the receiver |
| rx_en | input | 1 | Receive enable |
| err_irq_only | input | 1 | 1: error frames raise only the error interrupt |
| den_wr | input | 1 | Write strobe for the data-enable flag |
| den_wdata | input | 1 | Value written to the data-enable flag |
| den_o | output | 1 | Data-enable flag readback |
| rxd | input | 1 | Serial input, idle high |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| rd_byte | input | 1 | One-clock pulse: software has read `rx_data` |
| rx_data | output | 8 | Last accepted byte |
| rx_addr | output | 1 | Marker bit of the last accepted byte |
| err_frame | output | 1 | Framing error of the last accepted frame |
| err_over | output | 1 | Overrun error of the last accepted frame |
| irq_rx | output | 1 | Receive-complete interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
The main function is driven with clean data frames, clean address frames, frames with a low stop bit under both interrupt modes, and back-to-back frames without a read in between. Comparing these separates the accept decision from the error decision and from the interrupt routing. The same data and address frames are then sent with the data-enable flag cleared. A data frame with a bad stop bit must leave no trace at all, while an address frame with the same defect must report a framing error. A short low glitch, a frame cut off by disabling, and a frame sent while disabled each check that the sampler returns to idle. In each of these three cases the next good frame must still arrive intact.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/mpuart_sampler.sv
module mpuart_sampler
    import mpuart_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          rxd,
    input  logic          tick,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          abit,
    output logic          stop_ok,
    output logic          busy
);
    localparam int NBITS = DW + 1;
    localparam int CW    = $clog2(OVS);
    localparam int BW    = $clog2(NBITS + 1);
    localparam int MID   = OVS / 2 - 1;

    typedef struct packed {
        rx_state_e        st;
        logic [CW-1:0]    cnt;
        logic [BW-1:0]    nbit;
        logic [NBITS-1:0] sh;
        logic             done;
        logic             stop_ok;
        logic [1:0]       sync;
    } samp_t;

    samp_t s_q, s_d;
    logic  rx_s;

    assign rx_s = s_q.sync[1];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[0], rxd};
        if (!run) begin
            s_d.st   = ST_IDLE;
            s_d.cnt  = '0;
            s_d.nbit = '0;
        end else if (tick) begin
            case (s_q.st)
                ST_IDLE: begin
                    if (!rx_s) begin
                        s_d.st  = ST_START;
                        s_d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (s_q.cnt == CW'(MID)) begin
                        s_d.cnt  = '0;
                        s_d.nbit = '0;
                        s_d.st   = rx_s ? ST_IDLE : ST_BITS;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_BITS: begin
                    if (s_q.cnt == CW'(OVS - 1)) begin
                        s_d.cnt = '0;
                        s_d.sh  = {rx_s, s_q.sh[NBITS-1:1]};
                        if (s_q.nbit == BW'(NBITS - 1)) begin
                            s_d.st = ST_STOP;
                        end else begin
                            s_d.nbit = s_q.nbit + 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (s_q.cnt == CW'(OVS - 1)) begin
                        s_d.cnt     = '0;
                        s_d.stop_ok = rx_s;
                        s_d.done    = 1'b1;
                        s_d.st      = ST_IDLE;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.sync <= 2'b11;
        end else begin
            s_q <= s_d;
        end
    end

    assign done    = s_q.done;
    assign data    = s_q.sh[DW-1:0];
    assign abit    = s_q.sh[NBITS-1];
    assign stop_ok = s_q.stop_ok;
    assign busy    = (s_q.st != ST_IDLE);
endmodule

// File: rtl/mpuart_den.sv
module mpuart_den (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic rx_en,
    input  logic wr,
    input  logic wdata,
    output logic den
);
    typedef struct packed {
        logic flag;
    } den_t;

    den_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (!(pwr_en && rx_en)) begin
            f_d.flag = 1'b1;
        end else if (wr) begin
            f_d.flag = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{flag: 1'b1};
        else        f_q <= f_d;
    end

    assign den = f_q.flag;
endmodule

// File: rtl/mpuart_accept.sv
module mpuart_accept #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] data,
    input  logic          abit,
    input  logic          stop_ok,
    input  logic          den,
    input  logic          err_only,
    input  logic          rd,
    output logic [DW-1:0] rx_data,
    output logic          rx_addr,
    output logic          err_frame,
    output logic          err_over,
    output logic          irq_rx,
    output logic          irq_err
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          addr;
        logic          fe;
        logic          oe;
        logic          full;
        logic          irq_rx;
        logic          irq_err;
    } acc_t;

    acc_t a_q, a_d;
    logic fe_n, oe_n, take;

    always_comb begin
        a_d         = a_q;
        a_d.irq_rx  = 1'b0;
        a_d.irq_err = 1'b0;
        if (rd) a_d.full = 1'b0;
        take = done && (den || abit);
        fe_n = !stop_ok;
        oe_n = a_d.full;
        if (take) begin
            a_d.data    = data;
            a_d.addr    = abit;
            a_d.fe      = fe_n;
            a_d.oe      = oe_n;
            a_d.full    = 1'b1;
            a_d.irq_err = fe_n || oe_n;
            a_d.irq_rx  = !(fe_n || oe_n) || !err_only;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign rx_data   = a_q.data;
    assign rx_addr   = a_q.addr;
    assign err_frame = a_q.fe;
    assign err_over  = a_q.oe;
    assign irq_rx    = a_q.irq_rx;
    assign irq_err   = a_q.irq_err;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_en,
    input  logic          rx_en,
    input  logic          err_irq_only,
    input  logic          den_wr,
    input  logic          den_wdata,
    output logic          den_o,
    input  logic          rxd,
    input  logic          baud_tick,
    input  logic          rd_byte,
    output logic [DW-1:0] rx_data,
    output logic          rx_addr,
    output logic          err_frame,
    output logic          err_over,
    output logic          irq_rx,
    output logic          irq_err
);
    logic          run;
    logic          f_done, f_abit, f_stop_ok, samp_busy;
    logic [DW-1:0] f_data;

    assign run = pwr_en && rx_en;

    mpuart_sampler #(.DW(DW), .OVS(OVS)) u_samp (
        .clk(clk), .rst_n(rst_n), .run(run), .rxd(rxd), .tick(baud_tick),
        .done(f_done), .data(f_data), .abit(f_abit), .stop_ok(f_stop_ok),
        .busy(samp_busy)
    );

    mpuart_den u_den (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en),
        .wr(den_wr), .wdata(den_wdata), .den(den_o)
    );

    mpuart_accept #(.DW(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .done(f_done), .data(f_data),
        .abit(f_abit), .stop_ok(f_stop_ok), .den(den_o),
        .err_only(err_irq_only), .rd(rd_byte), .rx_data(rx_data),
        .rx_addr(rx_addr), .err_frame(err_frame), .err_over(err_over),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_en,
    input logic rx_en,
    input logic err_irq_only,
    input logic den_o,
    input logic samp_busy,
    input logic irq_rx,
    input logic irq_err,
    input logic err_frame,
    input logic err_over
);
    // R7: flag held at 1 whenever the receiver is not powered and enabled
    p_den_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_en && rx_en) |=> den_o);

    // R11: sampler idle the cycle after a disable
    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_en && rx_en) |=> !samp_busy);

    // R8 / R9: error interrupt only with a reported error
    p_err_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (err_frame || err_over));

    // R6: in error-only mode a completion pulse means a clean frame
    p_mode_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && $past(err_irq_only)) |-> !(err_frame || err_over));

    // R1: completion interrupt is a single-cycle pulse
    p_irq_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |=> !irq_rx);
endmodule

bind mpuart_rx mpuart_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en),
    .err_irq_only(err_irq_only), .den_o(den_o), .samp_busy(samp_busy),
    .irq_rx(irq_rx), .irq_err(irq_err), .err_frame(err_frame),
    .err_over(err_over)
);

// File: tb/sim_mpuart_rx.sv
module sim_mpuart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b0, rx_en = 1'b0, err_irq_only = 1'b1;
    logic       den_wr = 1'b0, den_wdata = 1'b0;
    logic       rxd = 1'b1, baud_tick = 1'b0, rd_byte = 1'b0;
    logic       den_o, rx_addr, err_frame, err_over, irq_rx, irq_err;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    localparam int BITCLK = 32; // 16 ticks, one tick every 2 clocks

    typedef struct {
        logic [7:0] data;
        logic       addr, fe, oe, irx, ierr;
        string      tag;
    } ev_t;
    ev_t exp_q[$];

    always #5 clk = ~clk;

    mpuart_rx u0 (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en),
        .err_irq_only(err_irq_only), .den_wr(den_wr), .den_wdata(den_wdata),
        .den_o(den_o), .rxd(rxd), .baud_tick(baud_tick), .rd_byte(rd_byte),
        .rx_data(rx_data), .rx_addr(rx_addr), .err_frame(err_frame),
        .err_over(err_over), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    initial forever begin
        @(negedge clk) baud_tick = ~baud_tick;
    end

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [7:0] d, input logic a, input logic fe,
                             input logic oe, input logic irx, input logic ierr,
                             input string tag);
        ev_t e;
        e.data = d; e.addr = a; e.fe = fe; e.oe = oe;
        e.irx = irx; e.ierr = ierr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic a, input logic stopb);
        rxd = 1'b0; hold(BITCLK);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; hold(BITCLK);
        end
        rxd = a;     hold(BITCLK);
        rxd = stopb; hold(BITCLK);
        rxd = 1'b1;  hold(3 * BITCLK);
    endtask

    task automatic read_byte();
        @(negedge clk) rd_byte = 1'b1;
        @(negedge clk) rd_byte = 1'b0;
    endtask

    task automatic write_den(input logic v);
        @(negedge clk) begin den_wr = 1'b1; den_wdata = v; end
        @(negedge clk) den_wr = 1'b0;
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (irq_rx || irq_err) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected result actual=%0h expected=none",
                         {irq_rx, irq_err, rx_data});
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                if ({rx_data, rx_addr, err_frame, err_over, irq_rx, irq_err} !==
                    {e.data, e.addr, e.fe, e.oe, e.irx, e.ierr}) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", e.tag,
                             {rx_data, rx_addr, err_frame, err_over, irq_rx, irq_err},
                             {e.data, e.addr, e.fe, e.oe, e.irx, e.ierr});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        hold(4);
        rst_n = 1'b1;
        hold(2);
        // R10 reset state
        chk(den_o === 1'b1, "R10 den", den_o, 1);
        chk({err_frame, err_over, irq_rx, irq_err} === 4'b0, "R10 flags",
            {err_frame, err_over, irq_rx, irq_err}, 0);
        chk(rx_data === 8'h00, "R10 data", rx_data, 0);

        // R7 write lock
        write_den(1'b0);
        chk(den_o === 1'b1, "R7 unpowered", den_o, 1);
        pwr_en = 1'b1;
        write_den(1'b0);
        chk(den_o === 1'b1, "R7 rx off", den_o, 1);
        rx_en = 1'b1;
        write_den(1'b0);
        chk(den_o === 1'b0, "R7 clear", den_o, 0);
        write_den(1'b1);
        chk(den_o === 1'b1, "R7 set", den_o, 1);
        write_den(1'b0);
        rx_en = 1'b0; hold(2);
        chk(den_o === 1'b1, "R7 forced", den_o, 1);
        rx_en = 1'b1; hold(BITCLK);

        // R1 data and address frames
        expect_ev(8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 data");
        send(8'hA5, 1'b0, 1'b1); read_byte();
        expect_ev(8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1 addr");
        send(8'h3C, 1'b1, 1'b1); read_byte();

        // R2 false start
        rxd = 1'b0; hold(6); rxd = 1'b1; hold(2 * BITCLK);
        expect_ev(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 after glitch");
        send(8'h5A, 1'b0, 1'b1); read_byte();

        // R8 / R6 framing error in both modes
        err_irq_only = 1'b1;
        expect_ev(8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R8 R6 err only");
        send(8'h81, 1'b0, 1'b0); read_byte();
        err_irq_only = 1'b0;
        expect_ev(8'h7E, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R6 both irqs");
        send(8'h7E, 1'b0, 1'b0); read_byte();
        err_irq_only = 1'b1;

        // R9 overrun
        expect_ev(8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 first");
        send(8'h11, 1'b0, 1'b1);
        expect_ev(8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9 overrun");
        send(8'h22, 1'b0, 1'b1);
        read_byte();

        // R4 dropped data frames
        write_den(1'b0);
        chk(den_o === 1'b0, "R4 den cleared", den_o, 0);
        send(8'h99, 1'b0, 1'b0);
        send(8'h98, 1'b0, 1'b1);
        chk(rx_data === 8'h22, "R4 data kept", rx_data, 8'h22);
        chk(err_frame === 1'b0, "R4 fe kept", err_frame, 0);
        chk(err_over === 1'b1, "R4 oe kept", err_over, 1);
        chk(rx_addr === 1'b0, "R4 addr kept", rx_addr, 0);

        // R3 address accepted with den cleared
        expect_ev(8'h42, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R3 addr den0");
        send(8'h42, 1'b1, 1'b1); read_byte();

        // R5 address with bad stop while den cleared
        expect_ev(8'h43, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5 addr error");
        send(8'h43, 1'b1, 1'b0); read_byte();
        write_den(1'b1);

        // R11 disable mid-frame, then frame while disabled
        rxd = 1'b0; hold(BITCLK);
        rxd = 1'b1; hold(2 * BITCLK);
        rx_en = 1'b0; hold(BITCLK);
        rxd = 1'b0; hold(4 * BITCLK);
        rxd = 1'b1; hold(BITCLK);
        send(8'hC3, 1'b1, 1'b1);
        chk(rx_data === 8'h43, "R11 nothing while off", rx_data, 8'h43);
        rx_en = 1'b1; hold(BITCLK);
        expect_ev(8'h6B, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R11 after re-enable");
        send(8'h6B, 1'b0, 1'b1); read_byte();

        hold(BITCLK);
        chk(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule